// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block turns one high-level request into the complete byte sequence that a serial NOR flash expects on its SPI bus. A request names the operation with a 4-bit select code. It also carries a 24-bit target address and a byte count, and is taken on a valid/ready handshake. The sequencer then drives a separate byte-level SPI engine one byte at a time. It issues a start strobe with the byte to shift out and waits for that engine's completion strobe, which returns the byte shifted in. It holds the active-low chip select low for the whole command and raises it after the final byte.

The framing depends on the operation:
- Write enable, write disable and whole-chip erase are a lone opcode byte.
- Status read is an opcode followed by one received byte.
- Sector and block erases are an opcode plus three address bytes.
- Data read and page program add a streamed data phase of the requested length. Read bytes leave as a valid-qualified stream, and program bytes are pulled from a ready/valid source that may stall.

Top module: `flash_cmd_sequencer`

## Requirements
- R1: Select codes map to opcode bytes: 0 write enable 0x06, 1 write disable 0x04, 2 read status 0x05, 3 read data 0x03, 4 page program 0x02, 5 sector erase 0x20, 6 32K block erase 0x52, 7 64K block erase 0xD8, 8 chip erase 0xC7.
- R2: Write enable, write disable and chip erase transfer exactly one byte (the opcode), and every transfer start happens while csN is low.
- R3: Select codes 5, 6 and 7 transfer the opcode and then the address as three bytes: bits 23:16, then 15:8, then 7:0, with no further bytes.
- R4: Read status transfers the opcode, then one fill byte 0xFF. The byte received for that fill is presented once on rdData with rdValid.
- R5: Read data transfers opcode, three address bytes, then count fill bytes of 0xFF. Each byte received during the fill bytes appears once, in order, on rdData with rdValid.
- R6: Page program transfers opcode, three address bytes, then count bytes taken from wrData. A byte is consumed only when wrValid and wrReady are both high, and no data-phase transfer starts while wrValid is low.
- R7: A count of zero on read data or page program transfers only the opcode and the three address bytes.
- R8: cmdReady is high only while no command is in progress. cmdValid asserted while busy is ignored and adds no bytes.
- R9: done is a single-cycle pulse in the cycle csN returns high, once per command.
- R10: At most one byte transfer is outstanding: a new xferStart occurs only after xferDone for the previous one.
- R11: A select code of 9 to 15 is dropped. csN stays high, no transfer starts and no done pulse occurs.
- R12: While reset is active, csN is high, cmdReady is high, and xferStart, done, rdValid and wrReady are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Sequencer idle, request taken this cycle |
| cmdSel | input | 4 | Operation select code |
| cmdAddr | input | 24 | Flash byte address |
| cmdCount | input | 16 | Data phase length in bytes |
| done | output | 1 | Command finished, one cycle |
| wrData | input | 8 | Program data byte |
| wrValid | input | 1 | Program data available |
| wrReady | output | 1 | Program data byte consumed |
| rdData | output | 8 | Received data byte |
| rdValid | output | 1 | rdData holds a new byte |
| xferStart | output | 1 | Start one SPI byte transfer |
| xferTx | output | 8 | Byte to shift out |
| xferDone | input | 1 | SPI byte transfer finished |
| xferRx | input | 8 | Byte shifted in |
| csN | output | 1 | Flash chip select, active low |

## Verification
Three situations are hard to reach from the ports:
- A request arriving while a command is already running. The stimulus holds cmdValid with a chip-erase select for several cycles in the middle of a long read with a slow SPI engine. The scoreboard must then see no extra byte and no early chip-select rise.
- A program source that starves the sequencer mid-stream. wrValid is gapped every third cycle, and wrData reads zero while invalid, so a start without data shows up as a wrong byte.
- The last received byte, whose rdValid falls in the same cycle as done. Back-to-back commands are issued on the done cycle itself to cover this.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam logic [3:0] SEL_WREN = 4'd0;
  localparam logic [3:0] SEL_WRDI = 4'd1;
  localparam logic [3:0] SEL_RDSR = 4'd2;
  localparam logic [3:0] SEL_READ = 4'd3;
  localparam logic [3:0] SEL_PROG = 4'd4;
  localparam logic [3:0] SEL_SE   = 4'd5;
  localparam logic [3:0] SEL_BE32 = 4'd6;
  localparam logic [3:0] SEL_BE64 = 4'd7;
  localparam logic [3:0] SEL_CE   = 4'd8;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  typedef enum logic [1:0] {TX_OPC, TX_ADDR, TX_WDATA, TX_FILL} txSel_e;

  typedef struct packed {
    logic   load;
    logic   capRx;
    logic   nextAddr;
    logic   decCount;
    txSel_e txSel;
  } seqStrobe_t;

  function automatic logic selSupported(input logic [3:0] sel);
    return sel <= SEL_CE;
  endfunction

  function automatic logic selHasAddr(input logic [3:0] sel);
    return (sel == SEL_READ) || (sel == SEL_PROG) || (sel == SEL_SE) ||
           (sel == SEL_BE32) || (sel == SEL_BE64);
  endfunction

  function automatic logic selHasData(input logic [3:0] sel);
    return (sel == SEL_READ) || (sel == SEL_PROG);
  endfunction

  function automatic logic [7:0] opcodeOf(input logic [3:0] sel);
    logic [7:0] op;
    case (sel)
      SEL_WREN: op = 8'h06;
      SEL_WRDI: op = 8'h04;
      SEL_RDSR: op = 8'h05;
      SEL_READ: op = 8'h03;
      SEL_PROG: op = 8'h02;
      SEL_SE:   op = 8'h20;
      SEL_BE32: op = 8'h52;
      SEL_BE64: op = 8'hD8;
      SEL_CE:   op = 8'hC7;
      default:  op = 8'h00;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/flash_seq_datapath.sv
module flash_seq_datapath
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [3:0]        cmdSel,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [7:0]        wrData,
  input  logic [7:0]        xferRx,
  output logic [7:0]        xferTx,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic [3:0]        curSel,
  output logic              addrLast,
  output logic              cntZero,
  output logic              cntLast
);

  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int IDX_W      = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  logic [ADDR_W-1:0] addrReg;
  logic [CNT_W-1:0]  cntReg;
  logic [IDX_W-1:0]  addrIdx;
  logic [7:0]        addrBytes [ADDR_BYTES];

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_addrByte
    assign addrBytes[b] = addrReg[b*8 +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSel  <= '0;
      addrReg <= '0;
      cntReg  <= '0;
      addrIdx <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.capRx;
      if (strobe.capRx) rdData <= xferRx;
      if (strobe.load) begin
        curSel  <= cmdSel;
        addrReg <= cmdAddr;
        cntReg  <= cmdCount;
        addrIdx <= IDX_W'(ADDR_BYTES - 1);
      end else begin
        if (strobe.nextAddr) addrIdx <= addrIdx - 1'b1;
        if (strobe.decCount) cntReg  <= cntReg - 1'b1;
      end
    end
  end

  assign addrLast = (addrIdx == '0);
  assign cntZero  = (cntReg == '0);
  assign cntLast  = (cntReg == CNT_W'(1));

  always_comb begin
    case (strobe.txSel)
      TX_OPC:   xferTx = opcodeOf(curSel);
      TX_ADDR:  xferTx = addrBytes[addrIdx];
      TX_WDATA: xferTx = wrData;
      default:  xferTx = FILL_BYTE;
    endcase
  end

  AST_NO_COUNT_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decCount |-> !cntZero); // R5
  AST_NO_ADDR_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.nextAddr |-> !addrLast); // R3

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [3:0] cmdSel,
  input  logic       xferDone,
  input  logic       wrValid,
  input  logic [3:0] curSel,
  input  logic       addrLast,
  input  logic       cntZero,
  input  logic       cntLast,
  output logic       cmdReady,
  output logic       xferStart,
  output logic       wrReady,
  output logic       csN,
  output logic       done,
  output seqStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} state_e;
  typedef enum logic [1:0] {PH_OPC, PH_ADDR, PH_DATA, PH_STAT} phase_e;

  state_e state, stateNext;
  phase_e phase, phaseNext;
  logic   finish;
  logic   isProg, isRead;

  assign isProg = (curSel == SEL_PROG);
  assign isRead = (curSel == SEL_READ);

  always_comb begin
    strobe       = '0;
    strobe.txSel = TX_OPC;
    stateNext    = state;
    phaseNext    = phase;
    finish       = 1'b0;
    xferStart    = 1'b0;
    wrReady      = 1'b0;
    cmdReady     = (state == ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (cmdValid && selSupported(cmdSel)) begin
          strobe.load = 1'b1;
          stateNext   = ST_SEND;
          phaseNext   = PH_OPC;
        end
      end
      ST_SEND: begin
        case (phase)
          PH_OPC:  strobe.txSel = TX_OPC;
          PH_ADDR: strobe.txSel = TX_ADDR;
          PH_DATA: strobe.txSel = isProg ? TX_WDATA : TX_FILL;
          default: strobe.txSel = TX_FILL;
        endcase
        if (!(phase == PH_DATA && isProg && !wrValid)) begin
          xferStart = 1'b1;
          wrReady   = (phase == PH_DATA) && isProg;
          stateNext = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (xferDone) begin
          strobe.capRx = (phase == PH_STAT) || (phase == PH_DATA && isRead);
          stateNext    = ST_SEND;
          case (phase)
            PH_OPC: begin
              if (selHasAddr(curSel))      phaseNext = PH_ADDR;
              else if (curSel == SEL_RDSR) phaseNext = PH_STAT;
              else                         finish    = 1'b1;
            end
            PH_ADDR: begin
              if (!addrLast)                          strobe.nextAddr = 1'b1;
              else if (selHasData(curSel) && !cntZero) phaseNext      = PH_DATA;
              else                                    finish          = 1'b1;
            end
            PH_DATA: begin
              strobe.decCount = 1'b1;
              if (cntLast) finish = 1'b1;
            end
            default: finish = 1'b1;
          endcase
          if (finish) stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= PH_OPC;
      csN   <= 1'b1;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
      done  <= finish;
      if (strobe.load)  csN <= 1'b0;
      else if (finish)  csN <= 1'b1;
    end
  end

  AST_START_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> !csN); // R2
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart); // R10
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> csN); // R8
  AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $rose(csN)); // R9
  AST_CS_RISE_HAS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> done); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_WR_TAKEN_WITH_START: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> (xferStart && wrValid)); // R6

endmodule

// File: rtl/flash_cmd_sequencer.sv
module flash_cmd_sequencer
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [3:0]        cmdSel,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [CNT_W-1:0]  cmdCount,
  output logic              done,
  input  logic [7:0]        wrData,
  input  logic              wrValid,
  output logic              wrReady,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              xferStart,
  output logic [7:0]        xferTx,
  input  logic              xferDone,
  input  logic [7:0]        xferRx,
  output logic              csN
);

  seqStrobe_t strobe;
  logic [3:0] curSel;
  logic       addrLast, cntZero, cntLast;

  flash_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdSel(cmdSel),
    .xferDone(xferDone), .wrValid(wrValid), .curSel(curSel),
    .addrLast(addrLast), .cntZero(cntZero), .cntLast(cntLast),
    .cmdReady(cmdReady), .xferStart(xferStart), .wrReady(wrReady),
    .csN(csN), .done(done), .strobe(strobe)
  );

  flash_seq_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdSel(cmdSel),
    .cmdAddr(cmdAddr), .cmdCount(cmdCount), .wrData(wrData),
    .xferRx(xferRx), .xferTx(xferTx), .rdData(rdData), .rdValid(rdValid),
    .curSel(curSel), .addrLast(addrLast), .cntZero(cntZero), .cntLast(cntLast)
  );

  AST_RD_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(!csN)); // R4

endmodule

// File: tb/test_flash_cmd_sequencer.sv
module test_flash_cmd_sequencer;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [3:0]  cmdSel = '0;
  logic [23:0] cmdAddr = '0;
  logic [15:0] cmdCount = '0;
  logic        done;
  logic [7:0]  wrData = '0;
  logic        wrValid = 1'b0;
  logic        wrReady;
  logic [7:0]  rdData;
  logic        rdValid;
  logic        xferStart;
  logic [7:0]  xferTx;
  logic        xferDone = 1'b0;
  logic [7:0]  xferRx = '0;
  logic        csN;

  always #4 clk = ~clk;

  flash_cmd_sequencer i_flash_cmd_sequencer (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdSel(cmdSel), .cmdAddr(cmdAddr), .cmdCount(cmdCount), .done(done),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady), .rdData(rdData),
    .rdValid(rdValid), .xferStart(xferStart), .xferTx(xferTx),
    .xferDone(xferDone), .xferRx(xferRx), .csN(csN)
  );

  int vectors = 0, fails = 0;
  int dones = 0, starts = 0, csLowCycles = 0, cycles = 0;
  logic [7:0] expTx[$];
  string      expTxTag[$];
  logic [7:0] expRd[$];
  string      expRdTag[$];

  int   engLat = 1;
  logic [7:0] rxBase = 8'h10;
  logic [7:0] progBase = 8'h50;
  int   progCount = 0, progStart = 0;
  bit   gapOn = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expOpcode(input logic [3:0] sel);
    case (sel)
      4'd0: return 8'h06;  4'd1: return 8'h04;  4'd2: return 8'h05;
      4'd3: return 8'h03;  4'd4: return 8'h02;  4'd5: return 8'h20;
      4'd6: return 8'h52;  4'd7: return 8'hD8;  default: return 8'hC7;
    endcase
  endfunction

  // program data source
  always @(negedge clk) begin
    wrValid = gapOn ? ((cycles % 3) != 0) : 1'b1;
    wrData  = wrValid ? progBase + 8'(progCount - progStart) : 8'h00;
    #1;
    if (wrValid && wrReady) progCount++;
  end

  // SPI byte engine model and monitor
  bit pending = 0, prevDone = 0;
  int delay = 0, pendIdx = 0, winIdx = 0;
  always @(negedge clk) begin
    #1;
    cycles++;
    if (rstN) begin
      if (csN) winIdx = 0;
      else csLowCycles++;
      if (xferDone) xferDone = 1'b0;
      if (pending) begin
        if (delay == 0) begin
          xferDone = 1'b1;
          xferRx   = rxBase + 8'(pendIdx);
          pending  = 0;
        end else delay--;
      end
      if (xferStart) begin
        starts++;
        check(!pending, "R10 start while busy", 1, 0);
        check(!csN, "R2 start outside frame", csN, 0);
        if (expTx.size() == 0) check(0, "R8 unexpected byte", xferTx, 0);
        else begin
          string t; logic [7:0] e;
          e = expTx.pop_front(); t = expTxTag.pop_front();
          check(xferTx == e, t, xferTx, e);
        end
        pending = 1; delay = engLat; pendIdx = winIdx; winIdx++;
      end
      if (rdValid) begin
        if (expRd.size() == 0) check(0, "R5 unexpected rdValid", rdData, 0);
        else begin
          string t; logic [7:0] e;
          e = expRd.pop_front(); t = expRdTag.pop_front();
          check(rdData == e, t, rdData, e);
        end
      end
      if (done) begin
        dones++;
        check(csN && !prevDone, "R9 done shape", {csN, prevDone}, 2);
      end
      prevDone = done;
    end
  end

  task automatic pushTx(input logic [7:0] b, input string tag);
    expTx.push_back(b); expTxTag.push_back(tag);
  endtask

  task automatic runCmd(input logic [3:0] sel, input logic [23:0] addr, input int cnt,
                        input int lat, input bit gaps, input bit poke);
    int d0, w;
    string tagOp;
    engLat = lat; gapOn = gaps;
    rxBase = rxBase + 8'h21;
    progBase = progBase + 8'h13;
    progStart = progCount;
    tagOp = (sel == 4'd0 || sel == 4'd1 || sel == 4'd8) ? "R1/R2 opcode" : "R1 opcode";
    pushTx(expOpcode(sel), tagOp);
    if (sel >= 4'd3 && sel <= 4'd7) begin
      pushTx(addr[23:16], "R3 addr hi");
      pushTx(addr[15:8],  "R3 addr mid");
      pushTx(addr[7:0],   "R3 addr lo");
    end
    if (sel == 4'd2) begin
      pushTx(8'hFF, "R4 fill");
      expRd.push_back(rxBase + 8'd1); expRdTag.push_back("R4 status byte");
    end
    if (sel == 4'd3) for (int i = 0; i < cnt; i++) begin
      pushTx(8'hFF, "R5 fill");
      expRd.push_back(rxBase + 8'(4 + i)); expRdTag.push_back("R5 read byte");
    end
    if (sel == 4'd4) for (int i = 0; i < cnt; i++)
      pushTx(progBase + 8'(i), "R6 program byte");
    while (!cmdReady) @(negedge clk);
    d0 = dones;
    cmdValid = 1'b1; cmdSel = sel; cmdAddr = addr; cmdCount = 16'(cnt);
    @(negedge clk);
    cmdValid = 1'b0;
    if (poke) begin
      repeat (2) @(negedge clk);
      cmdValid = 1'b1; cmdSel = 4'd8;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk); #2;
        check(!cmdReady, "R8 ready while busy", cmdReady, 0);
      end
      cmdValid = 1'b0;
    end
    w = 0;
    while (dones == d0 && w < 3000) begin @(negedge clk); #2; w++; end
    check(dones == d0 + 1, "R9 one done per command", dones - d0, 1);
    check(expTx.size() == 0, (cnt == 0 && (sel == 4'd3 || sel == 4'd4)) ?
          "R7 missing bytes" : "R2 missing bytes", expTx.size(), 0);
    check(expRd.size() == 0, "R5 missing read bytes", expRd.size(), 0);
    expTx.delete(); expTxTag.delete(); expRd.delete(); expRdTag.delete();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    int d0, c0, s0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check(csN == 1'b1, "R12 csN", csN, 1);
    check(cmdReady == 1'b1, "R12 cmdReady", cmdReady, 1);
    check({xferStart, done, rdValid, wrReady} == 4'b0, "R12 strobes",
          {xferStart, done, rdValid, wrReady}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runCmd(4'd0, 24'h0, 0, 1, 0, 0);          // R1 R2 write enable
    runCmd(4'd1, 24'h0, 0, 0, 0, 0);          // R1 R2 write disable
    runCmd(4'd8, 24'h0, 0, 2, 0, 0);          // R1 R2 chip erase
    runCmd(4'd2, 24'h0, 0, 1, 0, 0);          // R4 status
    runCmd(4'd5, 24'hA1B2C3, 0, 1, 0, 0);     // R3 sector
    runCmd(4'd6, 24'h123456, 0, 0, 0, 0);     // R3 32K
    runCmd(4'd7, 24'hFEDCBA, 0, 3, 0, 0);     // R3 64K
    runCmd(4'd3, 24'h00F00F, 5, 1, 0, 0);     // R5 read
    runCmd(4'd3, 24'h0ABCDE, 0, 1, 0, 0);     // R7 read zero
    runCmd(4'd4, 24'h330011, 6, 0, 1, 0);     // R6 program with gaps
    runCmd(4'd4, 24'h440022, 0, 2, 1, 0);     // R7 program zero
    runCmd(4'd4, 24'h5500FF, 1, 1, 0, 0);     // R6 single byte
    runCmd(4'd3, 24'h778899, 8, 3, 0, 1);     // R8 poke while busy
    runCmd(4'd2, 24'h0, 0, 0, 0, 0);          // back-to-back status

    // R11 unsupported selects
    repeat (3) @(negedge clk);
    d0 = dones; c0 = csLowCycles; s0 = starts;
    cmdValid = 1'b1; cmdSel = 4'd9;
    @(negedge clk); cmdSel = 4'd15;
    @(negedge clk); cmdValid = 1'b0;
    repeat (20) @(negedge clk);
    #2;
    check(dones == d0, "R11 no done", dones - d0, 0);
    check(csLowCycles == c0, "R11 csN stays high", csLowCycles - c0, 0);
    check(starts == s0, "R11 no transfer", starts - s0, 0);
    check(cmdReady == 1'b1, "R11 still idle", cmdReady, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule